// File: doc/BRIEF.md
# Strap-addressed I2C slave port

This block is the serial control port of a register-controlled device. It sits on a two-wire bus as a slave and lets an external master write and read a 256-entry array of 8-bit registers. Both bus lines are brought into the system clock domain through a flip-flop chain and edge-detected there. The port decodes start and stop conditions and the address byte, acknowledges its own address, and then either loads a register pointer and writes data with auto-increment, or streams data back from the pointer.

The 7-bit bus address is fixed by a strap pin after reset. The strap is sampled on successive system clock edges. Its level is taken only once four samples in a row agree. The strap then selects address bit 0 on top of a base address, and the choice holds until the next reset. A boot-busy input tells the port that an on-chip boot master owns the bus. While it is high the port releases SDA, ignores all bus traffic and writes nothing. The system clock must run at 16 times the SCL rate or faster, so at 400 kHz SCL it must be at least 6.4 MHz.

Top module: `strap_i2c_slave`

## Requirements
- R1: With the strap resolved low the port answers to the 7-bit address 0x1A (address bytes 0x34 for write, 0x35 for read). With it resolved high the port answers to 0x1B (0x36 write, 0x37 read). The strap sets address bit 0.
- R2: When the address byte (7 address bits MSB first, then R/W in bit 0) matches, the port holds SDA low through the ninth SCL pulse. It also acknowledges each byte the master writes. The port starts driving SDA only while SCL is low.
- R3: After an address byte that does not match, the port leaves SDA released for every following pulse until the next start condition.
- R4: In a write, the first byte after the address loads the 8-bit register pointer. Each later byte is stored at the pointer, and the pointer then increments modulo 256 (0xFF wraps to 0x00).
- R5: In a read, the port sends the register at the pointer MSB first and increments the pointer modulo 256. It sends further bytes for as long as the master acknowledges.
- R6: A master NACK (SDA high on the ninth pulse of a read byte) ends the read. The port leaves SDA released until the next start condition.
- R7: A stop condition (SDA rising while SCL is high) returns the port to idle with SDA released. A repeated start begins a new address phase and keeps the register pointer.
- R8: While boot_busy is high, the port releases SDA at the next clock edge, including in the middle of an acknowledge. It acknowledges nothing and writes no register. After boot_busy falls, it waits for a fresh start condition.
- R9: A strap change after the address has been resolved has no effect until the next reset.
- R10: During reset and right after it, sda_oe is low.
- R11: The strap level is accepted only after four consecutive equal samples. A disagreeing sample restarts the count. Until the level is accepted, the port answers to no address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_in | input | 1 | Address strap; its resolved level becomes address bit 0 |
| boot_busy | input | 1 | High while the on-chip boot master owns the bus |
| scl_in | input | 1 | SCL level seen at the pad |
| sda_in | input | 1 | SDA level seen at the pad (wired-AND bus level) |
| sda_oe | output | 1 | High to pull SDA low; low to release it |

## Verification
The functions most likely to collide in one cycle are the boot-busy override and the port's own acknowledge drive. The bench raises boot_busy on the clock right after it has seen the port pull SDA low for an address acknowledge. It requires SDA to be released at the very next sample. It then requires that the rest of that transfer is neither acknowledged nor stored. A second collision sits between strap resolution and bus traffic: the strap toggles in a three-high/three-low pattern while a master addresses both candidate addresses. A behavioural monitor compares SDA against an expected-quiet flag on every clock, so no acknowledge may appear before four samples agree.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } slv_state_t;

   typedef enum logic [1:0] {
      BK_ADDR,
      BK_PTR,
      BK_DATA
   } byte_kind_t;

   localparam int BYTE_W = 8;
   localparam int DEV_ADDR_W = 7;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_d, sda_d;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q[0] <= 1'b1;
               sda_q[0] <= 1'b1;
            end else begin
               scl_q[0] <= scl_in;
               sda_q[0] <= sda_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q[i] <= 1'b1;
               sda_q[i] <= 1'b1;
            end else begin
               scl_q[i] <= scl_q[i-1];
               sda_q[i] <= sda_q[i-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_q[STAGES-1];
         sda_d <= sda_q[STAGES-1];
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/strap_addr_latch.sv
module strap_addr_latch #(
   parameter int               ADDR_W    = 7,
   parameter logic [ADDR_W-1:0] BASE     = 7'h1A,
   parameter int               STRAP_BIT = 0,
   parameter int               SAMPLES   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_in,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] dev_addr
);
   localparam int CW = $clog2(SAMPLES + 1);

   logic [CW-1:0] agree_cnt;
   logic          lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         agree_cnt  <= '0;
         lvl        <= 1'b0;
         addr_valid <= 1'b0;
      end else if (!addr_valid) begin
         if (agree_cnt == '0 || strap_in != lvl) begin
            lvl       <= strap_in;
            agree_cnt <= CW'(1);
         end else if (agree_cnt == CW'(SAMPLES - 1)) begin
            addr_valid <= 1'b1;
         end else begin
            agree_cnt <= agree_cnt + CW'(1);
         end
      end
   end

   always_comb begin
      dev_addr            = BASE;
      dev_addr[STRAP_BIT] = lvl;
   end
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
   import i2c_slv_pkg::*;
#(
   parameter int PTR_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  boot_busy,
   input  logic                  addr_valid,
   input  logic [DEV_ADDR_W-1:0] dev_addr,
   input  logic                  sda_s,
   input  logic                  scl_rise,
   input  logic                  scl_fall,
   input  logic                  start_det,
   input  logic                  stop_det,
   input  logic [BYTE_W-1:0]     rdata,
   output logic                  we,
   output logic [BYTE_W-1:0]     wdata,
   output logic [PTR_W-1:0]      ptr,
   output logic                  sda_oe
);
   slv_state_t       state;
   byte_kind_t       kind;
   logic [3:0]       bitcnt;
   logic [BYTE_W-1:0] shreg, txsh;
   logic             rnw, nack;
   logic             active, byte_done;

   assign active    = !boot_busy && addr_valid && !stop_det && !start_det;
   assign byte_done = active && state == ST_RX && scl_fall && bitcnt == 4'd8;
   assign we        = byte_done && kind == BK_DATA;
   assign wdata     = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         kind   <= BK_ADDR;
         bitcnt <= '0;
         shreg  <= '0;
         txsh   <= '0;
         rnw    <= 1'b0;
         nack   <= 1'b0;
         ptr    <= '0;
         sda_oe <= 1'b0;
      end else if (boot_busy || !addr_valid || stop_det) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         state  <= ST_RX;
         kind   <= BK_ADDR;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            ST_RX: begin
               if (scl_rise) begin
                  shreg  <= {shreg[BYTE_W-2:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  case (kind)
                     BK_ADDR: begin
                        if (shreg[BYTE_W-1:1] == dev_addr) begin
                           rnw    <= shreg[0];
                           sda_oe <= 1'b1;
                           state  <= ST_ACK;
                        end else begin
                           state  <= ST_IDLE;
                        end
                     end
                     BK_PTR: begin
                        ptr    <= shreg[PTR_W-1:0];
                        sda_oe <= 1'b1;
                        state  <= ST_ACK;
                     end
                     default: begin
                        ptr    <= ptr + PTR_W'(1);
                        sda_oe <= 1'b1;
                        state  <= ST_ACK;
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (kind == BK_ADDR && rnw) begin
                     txsh   <= rdata;
                     ptr    <= ptr + PTR_W'(1);
                     sda_oe <= ~rdata[BYTE_W-1];
                     state  <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_RX;
                     kind   <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     sda_oe <= 1'b0;
                     state  <= ST_MACK;
                  end else begin
                     txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~txsh[BYTE_W-2];
                     bitcnt <= bitcnt + 4'd1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  nack <= sda_s;
               end else if (scl_fall) begin
                  if (nack) begin
                     state <= ST_IDLE;
                  end else begin
                     bitcnt <= '0;
                     txsh   <= rdata;
                     ptr    <= ptr + PTR_W'(1);
                     sda_oe <= ~rdata[BYTE_W-1];
                     state  <= ST_TX;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/strap_i2c_slave.sv
module strap_i2c_slave
   import i2c_slv_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE     = 7'h1A,
   parameter int         STRAP_BIT     = 0,
   parameter int         STRAP_SAMPLES = 4,
   parameter int         SYNC_STAGES   = 2,
   parameter int         PTR_W         = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strap_in,
   input  logic boot_busy,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_oe
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STRAP_SAMPLES < 2) begin : g_bad_samples
      $error("STRAP_SAMPLES must be at least 2");
   end
   if (STRAP_BIT < 0 || STRAP_BIT >= DEV_ADDR_W) begin : g_bad_bit
      $error("STRAP_BIT must index the 7-bit address");
   end
   if (PTR_W < 1 || PTR_W > BYTE_W) begin : g_bad_ptr
      $error("PTR_W must fit in one bus byte");
   end

   logic                  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic                  addr_valid;
   logic [DEV_ADDR_W-1:0] dev_addr;
   logic                  we;
   logic [BYTE_W-1:0]     wdata, rdata;
   logic [PTR_W-1:0]      ptr;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   strap_addr_latch #(
      .ADDR_W(DEV_ADDR_W), .BASE(ADDR_BASE),
      .STRAP_BIT(STRAP_BIT), .SAMPLES(STRAP_SAMPLES)
   ) u_strap (
      .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
      .addr_valid(addr_valid), .dev_addr(dev_addr)
   );

   i2c_slave_fsm #(.PTR_W(PTR_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .boot_busy(boot_busy),
      .addr_valid(addr_valid), .dev_addr(dev_addr), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .rdata(rdata),
      .we(we), .wdata(wdata), .ptr(ptr), .sda_oe(sda_oe)
   );

   i2c_reg_array #(.AW(PTR_W), .DW(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(we), .addr(ptr),
      .wdata(wdata), .rdata(rdata)
   );
endmodule

// File: rtl/strap_i2c_slave_chk.sv
module strap_i2c_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       boot_busy,
   input logic       scl_s,
   input logic       stop_det,
   input logic       addr_valid,
   input logic [6:0] dev_addr,
   input logic       sda_oe
);
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R10: assert (!sda_oe);
      end
   end

   assert_boot_release_R8: assert property (
      @(posedge clk) disable iff (!rst_n) boot_busy |=> !sda_oe);

   assert_unresolved_quiet_R11: assert property (
      @(posedge clk) disable iff (!rst_n) !addr_valid |-> !sda_oe);

   assert_addr_frozen_R9: assert property (
      @(posedge clk) disable iff (!rst_n)
      (addr_valid && $past(addr_valid)) |-> $stable(dev_addr));

   assert_stop_release_R7: assert property (
      @(posedge clk) disable iff (!rst_n) stop_det |=> !sda_oe);

   assert_drive_on_low_R2: assert property (
      @(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_s);
endmodule

bind strap_i2c_slave strap_i2c_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .boot_busy(boot_busy), .scl_s(scl_s),
   .stop_det(stop_det), .addr_valid(addr_valid), .dev_addr(dev_addr),
   .sda_oe(sda_oe)
);

// File: tb/strap_i2c_slave_bench.sv
module strap_i2c_slave_bench;
   localparam int Q = 10;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, strap, busy, scl, msda;
   logic sda_oe;
   logic bus_sda;
   assign bus_sda = msda & ~sda_oe;

   strap_i2c_slave u_strap_i2c_slave (
      .clk(clk), .rst_n(rst_n), .strap_in(strap), .boot_busy(busy),
      .scl_in(scl), .sda_in(bus_sda), .sda_oe(sda_oe)
   );

   int checks = 0;
   int fails  = 0;
   logic [7:0] ref_mem [256];
   bit   exp_quiet = 1'b1;
   int   quiet_viol = 0;
   bit   wiggle = 1'b0;
   int   wc = 0;

   // per-clock reference comparison: slave must be passive when the model says so
   always @(negedge clk) begin
      if (exp_quiet && sda_oe === 1'b1) quiet_viol++;
   end

   always @(negedge clk) begin
      if (wiggle) begin
         wc++;
         strap <= ((wc % 6) < 3);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      msda = 1'b1; tick(Q);
      scl  = 1'b1; tick(Q);
      msda = 1'b0; tick(Q);
      scl  = 1'b0; tick(Q);
   endtask

   task automatic i2c_stop();
      msda = 1'b0; tick(Q);
      scl  = 1'b1; tick(Q);
      msda = 1'b1; tick(Q);
   endtask

   task automatic send8(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         msda = b[i]; tick(Q);
         scl = 1'b1; tick(2 * Q);
         scl = 1'b0; tick(Q);
      end
   endtask

   task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input string req);
      logic acked;
      send8(b);
      msda = 1'b1; tick(Q);
      scl = 1'b1; tick(Q);
      acked = (bus_sda == 1'b0);
      tick(Q);
      scl = 1'b0; tick(Q);
      chk(req, 32'(acked), 32'(exp_ack));
   endtask

   task automatic rd_byte(input logic [7:0] exp, input bit give_nack, input string req);
      logic [7:0] d;
      msda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl = 1'b1; tick(Q);
         d[i] = bus_sda;
         tick(Q);
         scl = 1'b0; tick(Q);
      end
      msda = give_nack; tick(Q);
      scl = 1'b1; tick(2 * Q);
      scl = 1'b0; tick(Q);
      msda = 1'b1;
      chk(req, 32'(d), 32'(exp));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(3);
      chk("R10 sda_oe in reset", 32'(sda_oe), 0);
      rst_n = 1'b1;
      tick(2);
      chk("R10 sda_oe after reset", 32'(sda_oe), 0);
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] p;
      rst_n = 1'b0; strap = 1'b0; busy = 1'b0; scl = 1'b1; msda = 1'b1;
      wiggle = 1'b1;
      exp_quiet = 1'b1;
      do_reset();

      // R11: strap never settles, no address answered
      i2c_start();
      wr_byte(8'h34, 1'b0, "R11 unresolved 0x34");
      i2c_stop();
      i2c_start();
      wr_byte(8'h36, 1'b0, "R11 unresolved 0x36");
      i2c_stop();
      wiggle = 1'b0;
      strap = 1'b1;
      tick(10);
      chk("R11 quiet before strap resolved", 32'(quiet_viol), 0);
      exp_quiet = 1'b0;

      // R1 high strap address, R9 later change ignored
      i2c_start();
      wr_byte(8'h36, 1'b1, "R1 strap high answers 0x36");
      i2c_stop();
      strap = 1'b0;
      tick(10);
      i2c_start();
      wr_byte(8'h34, 1'b0, "R9 late strap low ignored 0x34");
      i2c_stop();
      i2c_start();
      wr_byte(8'h37, 1'b1, "R9 still answers 0x37");
      rd_byte(8'h00, 1'b1, "R5 read after reset");
      i2c_stop();

      // new reset with strap low
      do_reset();
      exp_quiet = 1'b1;
      quiet_viol = 0;
      i2c_start();
      wr_byte(8'h36, 1'b0, "R3 mismatch 0x36 no ack");
      wr_byte(8'h34, 1'b0, "R3 stays idle until start");
      i2c_stop();
      tick(2);
      chk("R3 no drive after mismatch", 32'(quiet_viol), 0);
      exp_quiet = 1'b0;

      // R4 write with auto-increment
      i2c_start();
      wr_byte(8'h34, 1'b1, "R1 strap low answers 0x34");
      wr_byte(8'h10, 1'b1, "R2 pointer byte ack");
      wr_byte(8'hA5, 1'b1, "R4 data ack"); ref_mem[8'h10] = 8'hA5;
      wr_byte(8'h5A, 1'b1, "R4 data ack"); ref_mem[8'h11] = 8'h5A;
      wr_byte(8'hC3, 1'b1, "R4 data ack"); ref_mem[8'h12] = 8'hC3;
      i2c_stop();

      // R4 pointer wrap on write
      i2c_start();
      wr_byte(8'h34, 1'b1, "R2 address ack");
      wr_byte(8'hFF, 1'b1, "R4 pointer 0xFF");
      wr_byte(8'h11, 1'b1, "R4 data at 0xFF"); ref_mem[8'hFF] = 8'h11;
      wr_byte(8'h22, 1'b1, "R4 data wraps to 0x00"); ref_mem[8'h00] = 8'h22;
      i2c_stop();

      // R5/R6/R7 read with repeated start
      i2c_start();
      wr_byte(8'h34, 1'b1, "R2 address ack");
      wr_byte(8'h11, 1'b1, "R4 pointer 0x11");
      i2c_start();
      wr_byte(8'h35, 1'b1, "R7 repeated start read address ack");
      rd_byte(ref_mem[8'h11], 1'b0, "R5 read first byte");
      rd_byte(ref_mem[8'h12], 1'b0, "R5 read auto-increment");
      rd_byte(ref_mem[8'h13], 1'b1, "R5 read third byte");
      exp_quiet = 1'b1;
      quiet_viol = 0;
      wr_byte(8'hFF, 1'b0, "R6 nack ends read");
      chk("R6 quiet after nack", 32'(quiet_viol), 0);
      i2c_stop();
      exp_quiet = 1'b0;

      // R5 read wrap
      i2c_start();
      wr_byte(8'h34, 1'b1, "R2 address ack");
      wr_byte(8'hFF, 1'b1, "R4 pointer 0xFF");
      i2c_start();
      wr_byte(8'h35, 1'b1, "R7 read address ack");
      rd_byte(ref_mem[8'hFF], 1'b0, "R5 read at 0xFF");
      rd_byte(ref_mem[8'h00], 1'b1, "R5 read wraps to 0x00");
      i2c_stop();

      // R8 boot busy raised in the middle of an address acknowledge
      i2c_start();
      send8(8'h34);
      msda = 1'b1; tick(Q);
      scl = 1'b1; tick(Q);
      chk("R2 ack held before busy", 32'(bus_sda), 0);
      busy = 1'b1;
      tick(1);
      chk("R8 release on next clock", 32'(sda_oe), 0);
      exp_quiet = 1'b1;
      quiet_viol = 0;
      tick(Q);
      scl = 1'b0; tick(Q);
      wr_byte(8'h20, 1'b0, "R8 pointer not acked while busy");
      wr_byte(8'h99, 1'b0, "R8 data not acked while busy");
      i2c_stop();
      i2c_start();
      wr_byte(8'h34, 1'b0, "R8 start ignored while busy");
      i2c_stop();
      busy = 1'b0;
      tick(5);
      chk("R8 quiet during busy", 32'(quiet_viol), 0);
      exp_quiet = 1'b0;

      i2c_start();
      wr_byte(8'h34, 1'b1, "R8 normal after busy");
      wr_byte(8'h20, 1'b1, "R4 pointer 0x20");
      i2c_start();
      wr_byte(8'h35, 1'b1, "R7 read address ack");
      p = ref_mem[8'h20];
      rd_byte(p, 1'b1, "R8 no register written while busy");
      i2c_stop();

      tick(20);
      finish_run();
   end
endmodule